// File: doc/BRIEF.md
# Audio Interface Control and Status Registers

This block is the register file of a streaming audio interface. It is reached over a simple quadlet-addressed request bus that carries reads, writes and 64-bit compare-swap requests. Its registers are:

- a 64-bit owner address;
- a notification word;
- a clock-select register giving the sample source and rate code;
- a stream enable;
- a live clock status word;
- an extended status word with live per-source lock bits and sticky per-source slip flags.

When events occur, the block overwrites the notification word with the new event bits. If an owner is registered, it also raises a one-cycle notify strobe that carries the owner address and the event word. The bus transport, name strings and clock recovery are outside the block. Lock, slip, rate and configuration-change inputs come from neighbouring logic.

Every request is answered one cycle later. The owner can only be claimed or released with compare-swap. A bus reset drops the owner and stops streaming.

The quadlet map is as follows:

| Quadlet | Register |
|---|---|
| 0 | owner bits [63:32] |
| 1 | owner bits [31:0] |
| 2 | notification word |
| 3 | clock select |
| 4 | enable |
| 5 | status |
| 6 | extended status |

Request op codes: 0 = read, 1 = write, 2 = compare-swap.

Top module: `avcsr_top`

## Requirements
- R1: After reset, and in the cycle after any bus_reset pulse, the owner reads 0xFFFF0000 at quadlet 0 and 0x00000000 at quadlet 1 (the no-owner value).
- R2: A plain write to quadlet 0 or 1 leaves the owner unchanged.
- R3: A compare-swap addressed to quadlet 0 returns the previous 64-bit owner on rsp_old. It stores req_swap only when the previous owner equals req_cmp.
- R4: When any event bit is raised in a cycle, the notification word at quadlet 2 is replaced by exactly those bits. Earlier bits are not kept.
- R5: Event bit positions are as follows:
  - bit 0: rx_cfg_chg;
  - bit 1: tx_cfg_chg;
  - bit 4: a change of src_locked;
  - bit 5: a completed write to clock select;
  - bit 6: any change in lock_vec.
- R6: Clock select at quadlet 3 stores the source in bits [7:0] and the rate code in bits [15:8], and drives them on clk_src and clk_rate. Bits [31:16] of the write are ignored and read as zero. The reset value is source 12, rate 2.
- R7: Writing a nonzero value to quadlet 4 sets stream_en, and writing zero clears it. A bus_reset also clears it. Quadlet 4 reads back stream_en in bit 0.
- R8: Quadlet 5 reads src_locked in bit 0 and nominal_rate in bits [15:8].
- R9: Quadlet 6 reads the live lock_vec in bits [10:0] and sticky slip flags in bits [26:16]. A read returns the flags and then clears them, keeping only slips that arrive in the same cycle. Slips raise no event.
- R10: With an owner registered, an event produces notify_valid in the following cycle, with notify_addr set to the owner and notify_word set to the event bits. With no owner, no strobe is issued, but the notification word is still updated.
- R11: rsp_valid and rsp_rdata appear in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | Bus reset pulse |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 compare-swap |
| req_addr | input | AW | Quadlet index |
| req_wdata | input | 32 | Write data |
| req_cmp | input | 64 | Compare-swap compare operand |
| req_swap | input | 64 | Compare-swap new value |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | 32 | Read data |
| rsp_old | output | 64 | Previous owner on compare-swap |
| rx_cfg_chg | input | 1 | Receive configuration changed |
| tx_cfg_chg | input | 1 | Transmit configuration changed |
| src_locked | input | 1 | Current source locked |
| nominal_rate | input | 8 | Measured rate code |
| lock_vec | input | NSRC | Per-source lock |
| slip_vec | input | NSRC | Per-source slip pulses |
| clk_src | output | 8 | Selected source |
| clk_rate | output | 8 | Selected rate code |
| stream_en | output | 1 | Streaming enabled |
| notify_valid | output | 1 | Notification strobe |
| notify_addr | output | 64 | Notification destination |
| notify_word | output | 32 | Notification event bits |

## Verification
Every result is registered once, so all results fall due on the first clock edge after the cycle in which their cause is presented. This covers:

- read data and compare-swap return values;
- register updates and clock-select outputs;
- the notify strobe for an event;
- sticky slip capture.

The bench changes inputs on the falling edge and samples one time unit after the next rising edge. Each check therefore sees exactly that one cycle of delay. Slip clearing is checked by a second read of quadlet 6, and ignored owner writes are checked by reading quadlets 0 and 1 back.

// File: rtl/avcsr_pkg.sv
`timescale 1ns/1ps
package avcsr_pkg;
  localparam logic [63:0] NO_OWNER = 64'hFFFF_0000_0000_0000;
  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_CSWAP = 2'd2;
  localparam int Q_OWN_HI = 0;
  localparam int Q_OWN_LO = 1;
  localparam int Q_NOTIF  = 2;
  localparam int Q_CLKSEL = 3;
  localparam int Q_ENABLE = 4;
  localparam int Q_STATUS = 5;
  localparam int Q_EXT    = 6;
  localparam int SLIP_POS = 16;

  // event word assembly: bit positions fixed by the consumers of the word
  function automatic logic [31:0] ev_word(input logic rx, input logic tx,
      input logic cur_lock, input logic clk_acc, input logic ext_lock);
    logic [31:0] w;
    w = '0;
    w[0] = rx;
    w[1] = tx;
    w[4] = cur_lock;
    w[5] = clk_acc;
    w[6] = ext_lock;
    return w;
  endfunction

  function automatic logic [63:0] cswap_next(input logic [63:0] cur,
      input logic [63:0] cmp, input logic [63:0] swp);
    return (cur == cmp) ? swp : cur;
  endfunction
endpackage

// File: rtl/avcsr_owner.sv
`timescale 1ns/1ps
module avcsr_owner (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_reset,
  input  logic        cs_fire,
  input  logic [63:0] cs_cmp,
  input  logic [63:0] cs_swap,
  output logic [63:0] owner_o
);
  import avcsr_pkg::*;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         owner_o <= NO_OWNER;
    else if (bus_reset) owner_o <= NO_OWNER;
    else if (cs_fire)   owner_o <= cswap_next(owner_o, cs_cmp, cs_swap);
  end
endmodule

// File: rtl/avcsr_slip.sv
`timescale 1ns/1ps
module avcsr_slip #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] slip_i,
  input  logic         clr_i,
  output logic [N-1:0] slip_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slip_o <= '0;
    else        slip_o <= slip_i | (clr_i ? '0 : slip_o);
  end
endmodule

// File: rtl/avcsr_evt.sv
`timescale 1ns/1ps
module avcsr_evt #(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_i,
  input  logic         tx_i,
  input  logic         cur_lock_i,
  input  logic [N-1:0] lock_i,
  input  logic         clk_acc_i,
  input  logic [63:0]  owner_i,
  output logic [31:0]  notif_o,
  output logic         nv_o,
  output logic [63:0]  naddr_o,
  output logic [31:0]  nword_o,
  output logic [31:0]  ev_o
);
  import avcsr_pkg::*;
  logic         cur_q;
  logic [N-1:0] lock_q;

  assign ev_o = ev_word(rx_i, tx_i, cur_lock_i != cur_q, clk_acc_i, lock_i != lock_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= 1'b0;
      lock_q  <= '0;
      notif_o <= '0;
      nv_o    <= 1'b0;
      naddr_o <= NO_OWNER;
      nword_o <= '0;
    end else begin
      cur_q  <= cur_lock_i;
      lock_q <= lock_i;
      nv_o   <= (ev_o != '0) && (owner_i != NO_OWNER);
      if (ev_o != '0) begin
        notif_o <= ev_o;
        naddr_o <= owner_i;
        nword_o <= ev_o;
      end
    end
  end
endmodule

// File: rtl/avcsr_top.sv
`timescale 1ns/1ps
module avcsr_top #(
  parameter int NSRC = 11,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_reset,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [AW-1:0]   req_addr,
  input  logic [31:0]     req_wdata,
  input  logic [63:0]     req_cmp,
  input  logic [63:0]     req_swap,
  output logic            rsp_valid,
  output logic [31:0]     rsp_rdata,
  output logic [63:0]     rsp_old,
  input  logic            rx_cfg_chg,
  input  logic            tx_cfg_chg,
  input  logic            src_locked,
  input  logic [7:0]      nominal_rate,
  input  logic [NSRC-1:0] lock_vec,
  input  logic [NSRC-1:0] slip_vec,
  output logic [7:0]      clk_src,
  output logic [7:0]      clk_rate,
  output logic            stream_en,
  output logic            notify_valid,
  output logic [63:0]     notify_addr,
  output logic [31:0]     notify_word
);
  import avcsr_pkg::*;

  logic            is_rd, is_wr, is_cs;
  logic            wr_clksel, wr_enable, rd_ext, cs_fire;
  logic [63:0]     owner_q;
  logic [NSRC-1:0] slip_q;
  logic [31:0]     notif_q, ev_now, rd_mux, ext_word;

  assign is_rd     = req_valid && (req_op == OP_RD);
  assign is_wr     = req_valid && (req_op == OP_WR);
  assign is_cs     = req_valid && (req_op == OP_CSWAP);
  assign wr_clksel = is_wr && (req_addr == AW'(Q_CLKSEL));
  assign wr_enable = is_wr && (req_addr == AW'(Q_ENABLE));
  assign rd_ext    = is_rd && (req_addr == AW'(Q_EXT));
  assign cs_fire   = is_cs && (req_addr == AW'(Q_OWN_HI));

  avcsr_owner u_owner (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .cs_fire(cs_fire),
    .cs_cmp(req_cmp), .cs_swap(req_swap), .owner_o(owner_q)
  );

  avcsr_slip #(.N(NSRC)) u_slip (
    .clk(clk), .rst_n(rst_n), .slip_i(slip_vec), .clr_i(rd_ext), .slip_o(slip_q)
  );

  avcsr_evt #(.N(NSRC)) u_evt (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_cfg_chg), .tx_i(tx_cfg_chg),
    .cur_lock_i(src_locked), .lock_i(lock_vec), .clk_acc_i(wr_clksel),
    .owner_i(owner_q), .notif_o(notif_q), .nv_o(notify_valid),
    .naddr_o(notify_addr), .nword_o(notify_word), .ev_o(ev_now)
  );

  always_comb begin
    ext_word = '0;
    ext_word[NSRC-1:0] = lock_vec;
    ext_word[SLIP_POS +: NSRC] = slip_q;
  end

  always_comb begin
    case (req_addr)
      AW'(Q_OWN_HI): rd_mux = owner_q[63:32];
      AW'(Q_OWN_LO): rd_mux = owner_q[31:0];
      AW'(Q_NOTIF):  rd_mux = notif_q;
      AW'(Q_CLKSEL): rd_mux = {16'h0, clk_rate, clk_src};
      AW'(Q_ENABLE): rd_mux = {31'h0, stream_en};
      AW'(Q_STATUS): rd_mux = {16'h0, nominal_rate, 7'h0, src_locked};
      AW'(Q_EXT):    rd_mux = ext_word;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_src   <= 8'd12;
      clk_rate  <= 8'd2;
      stream_en <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_old   <= '0;
    end else begin
      if (wr_clksel) begin
        clk_src  <= req_wdata[7:0];
        clk_rate <= req_wdata[15:8];
      end
      if (bus_reset)      stream_en <= 1'b0;
      else if (wr_enable) stream_en <= (req_wdata != '0);
      rsp_valid <= req_valid;
      rsp_rdata <= is_rd ? rd_mux : '0;
      rsp_old   <= cs_fire ? owner_q : '0;
    end
  end
endmodule

// File: rtl/avcsr_chk.sv
`timescale 1ns/1ps
module avcsr_chk #(
  parameter int N  = 11,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_reset,
  input logic          req_valid,
  input logic [1:0]    req_op,
  input logic [AW-1:0] req_addr,
  input logic [63:0]   owner_q,
  input logic          stream_en,
  input logic          notify_valid,
  input logic [63:0]   notify_addr,
  input logic [31:0]   notify_word,
  input logic [N-1:0]  slip_vec,
  input logic [N-1:0]  slip_q
);
  localparam logic [63:0] NOOWN = 64'hFFFF_0000_0000_0000;

  assert_owner_busrst_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (owner_q == NOOWN));

  assert_owner_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd1 && !bus_reset) |=> $stable(owner_q));

  assert_notify_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (notify_word != '0));

  assert_enable_busrst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !stream_en);

  assert_slip_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 2'd0 && req_addr == AW'(6) && slip_vec == '0) |=> (slip_q == '0));

  assert_no_owner_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> (notify_addr != NOOWN));
endmodule

bind avcsr_top avcsr_chk #(.N(NSRC), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .req_valid(req_valid),
  .req_op(req_op), .req_addr(req_addr), .owner_q(owner_q), .stream_en(stream_en),
  .notify_valid(notify_valid), .notify_addr(notify_addr), .notify_word(notify_word),
  .slip_vec(slip_vec), .slip_q(slip_q)
);

// File: tb/avcsr_top_tb_top.sv
`timescale 1ns/1ps
module avcsr_top_tb_top;
  logic clk = 0, rst_n = 0, bus_reset = 0, req_valid = 0;
  logic [1:0] req_op = 0;
  logic [2:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [63:0] req_cmp = 0, req_swap = 0;
  logic rsp_valid, stream_en, notify_valid;
  logic [31:0] rsp_rdata, notify_word;
  logic [63:0] rsp_old, notify_addr;
  logic rx_cfg_chg = 0, tx_cfg_chg = 0, src_locked = 0;
  logic [7:0] nominal_rate = 0, clk_src, clk_rate;
  logic [10:0] lock_vec = 0, slip_vec = 0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] r_rd; logic [63:0] r_old, r_na; logic r_nv; logic [31:0] r_nw;

  localparam logic [63:0] OWN = 64'hFFC1_0000_0000_1000;

  avcsr_top dut_i (.*);

  always #2.5 clk = ~clk;

  // {op, addr, wdata, check, expected}
  localparam int NV = 8;
  localparam logic [69:0] VEC [0:NV-1] = '{
    {2'd0, 3'd0, 32'h0,          1'b1, 32'hFFFF0000},  // R1
    {2'd0, 3'd1, 32'h0,          1'b1, 32'h00000000},  // R1
    {2'd1, 3'd3, 32'h0000_0405,  1'b0, 32'h0},
    {2'd0, 3'd2, 32'h0,          1'b1, 32'h00000020},  // R10 notif updated w/o owner
    {2'd1, 3'd0, 32'h1234_5678,  1'b0, 32'h0},
    {2'd0, 3'd0, 32'h0,          1'b1, 32'hFFFF0000},  // R2
    {2'd1, 3'd4, 32'h7,          1'b0, 32'h0},
    {2'd0, 3'd4, 32'h0,          1'b1, 32'h00000001}   // R7
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cap();
    r_rd = rsp_rdata; r_old = rsp_old; r_nv = notify_valid; r_na = notify_addr; r_nw = notify_word;
  endtask

  task automatic req(input logic [1:0] op, input logic [2:0] a, input logic [31:0] d,
                     input logic [63:0] c, input logic [63:0] s);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_cmp = c; req_swap = s;
    @(posedge clk); #1;
    cap();
    req_valid = 0;
  endtask

  task automatic ev(input logic rx, input logic tx, input logic [10:0] sl);
    @(negedge clk);
    rx_cfg_chg = rx; tx_cfg_chg = tx; slip_vec = sl;
    @(posedge clk); #1;
    cap();
    rx_cfg_chg = 0; tx_cfg_chg = 0; slip_vec = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R11 rsp_valid idle", rsp_valid, 0);
    chk("R10 notify idle", notify_valid, 0);
    chk("R7 stream_en reset", stream_en, 0);
    chk("R6 clk_src reset", clk_src, 12);
    chk("R6 clk_rate reset", clk_rate, 2);

    for (int i = 0; i < NV; i++) begin
      req(VEC[i][69:68], VEC[i][67:65], VEC[i][64:33], 0, 0);
      if (VEC[i][32]) chk($sformatf("R11 vec%0d", i), r_rd, VEC[i][31:0]);
    end
    req(2'd1, 3'd3, 32'hABCD_0C02, 0, 0);
    chk("R10 no strobe without owner", r_nv, 0);
    chk("R6 clk_src", clk_src, 8'h02);
    chk("R6 clk_rate", clk_rate, 8'h0C);
    req(2'd0, 3'd3, 0, 0, 0);
    chk("R6 upper bits dropped", r_rd, 32'h0000_0C02);
    req(2'd1, 3'd4, 0, 0, 0);
    chk("R7 zero write stops", stream_en, 0);

    req(2'd2, 3'd0, 0, 64'h0, OWN);
    chk("R3 old on mismatch", r_old, 64'hFFFF_0000_0000_0000);
    req(2'd0, 3'd0, 0, 0, 0);
    chk("R3 no swap on mismatch", r_rd, 32'hFFFF0000);
    req(2'd2, 3'd0, 0, 64'hFFFF_0000_0000_0000, OWN);
    chk("R3 old on match", r_old, 64'hFFFF_0000_0000_0000);
    req(2'd0, 3'd0, 0, 0, 0);
    chk("R3 owner hi", r_rd, 32'hFFC10000);
    req(2'd0, 3'd1, 0, 0, 0);
    chk("R3 owner lo", r_rd, 32'h00001000);

    ev(1, 1, 0);
    chk("R10 strobe", r_nv, 1);
    chk("R10 addr", r_na, OWN);
    chk("R5 rx/tx bits", r_nw, 32'h3);
    req(2'd0, 3'd2, 0, 0, 0);
    chk("R4 notif overwritten", r_rd, 32'h3);

    lock_vec = 11'h005; src_locked = 1;
    ev(0, 0, 0);
    chk("R5 lock bits", r_nw, 32'h50);
    chk("R10 strobe lock", r_nv, 1);

    req(2'd1, 3'd3, 32'h0000_0201, 0, 0);
    chk("R5 clock accepted strobe", r_nv, 1);
    chk("R5 clock accepted word", r_nw, 32'h20);

    nominal_rate = 8'h04;
    req(2'd0, 3'd5, 0, 0, 0);
    chk("R8 status", r_rd, 32'h0000_0401);

    ev(0, 0, 11'h008);
    chk("R9 slip no event", r_nv, 0);
    req(2'd0, 3'd6, 0, 0, 0);
    chk("R9 ext with slip", r_rd, 32'h0008_0005);
    req(2'd0, 3'd6, 0, 0, 0);
    chk("R9 slip cleared", r_rd, 32'h0000_0005);

    req(2'd1, 3'd4, 32'h1, 0, 0);
    chk("R7 start", stream_en, 1);
    @(negedge clk); bus_reset = 1;
    @(posedge clk); #1; bus_reset = 0;
    chk("R7 bus reset clears", stream_en, 0);
    req(2'd0, 3'd0, 0, 0, 0);
    chk("R1 owner after bus reset", r_rd, 32'hFFFF0000);
    ev(1, 0, 0);
    chk("R10 no strobe after bus reset", r_nv, 0);
    req(2'd0, 3'd2, 0, 0, 0);
    chk("R4 notif still updated", r_rd, 32'h1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule